// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with High and Low Result Registers

This unit multiplies or divides two 32-bit operands and leaves a 64-bit result split across two result registers, a high word and a low word. A multiply places the full product there, with the upper half in the high word and the lower half in the low word. A divide places the quotient in the low word and the remainder in the high word. Both operations come in a signed form and an unsigned form, selected by a two-bit operation code.

Work starts with a one-cycle start pulse. The unit then iterates one bit per cycle: a shift-add loop for multiply and a restoring loop for divide. While it iterates it raises busy. When it finishes it drops busy and raises done for one cycle. The two result registers are always visible on their own output ports, which serve as the move-from-high and move-from-low reads. They keep their previous contents until the running operation commits its result.

Top module: `mdu_unit`

## Requirements
- R1: After reset, busy and done are low and both hiOut and loOut read zero.
- R2: A start sampled at clock edge k while idle makes busy high after edges k through k+32. After edge k+33 busy is low and done is high for exactly one cycle.
- R3: opIn = 2'b00 (signed multiply) sets {hiOut, loOut} to the 64-bit two's-complement product of srcA and srcB.
- R4: opIn = 2'b01 (unsigned multiply) sets {hiOut, loOut} to the 64-bit product of both operands taken as unsigned.
- R5: opIn = 2'b10 (signed divide) sets loOut to the quotient truncated toward zero and hiOut to the remainder, which carries the sign of the dividend srcA. The most-negative value divided by -1 gives quotient 32'h8000_0000 and remainder 0.
- R6: opIn = 2'b11 (unsigned divide) sets loOut to the unsigned quotient and hiOut to the unsigned remainder.
- R7: A divide with srcB = 0, signed or unsigned, sets loOut to all ones and hiOut to srcA, and flags no error.
- R8: A start pulse while busy is ignored. The running operation keeps its operands, its result and its R2 timing.
- R9: While an operation runs, hiOut and loOut keep the values left by the previous operation (or the reset value).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | One-cycle request to begin an operation |
| opIn | input | 2 | Operation: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| srcA | input | WIDTH | Multiplicand or dividend |
| srcB | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | High while an operation is running |
| done | output | 1 | One-cycle pulse when results are committed |
| hiOut | output | WIDTH | High result register (product upper half or remainder) |
| loOut | output | WIDTH | Low result register (product lower half or quotient) |

## Verification
The bench builds the unit with its default WIDTH of 32. At that width the bench's 64-bit reference arithmetic can check every product bit and every quotient and remainder exactly. The operands include the extremes: the most-negative value, -1, all ones and zero. These exercise the sign-correction paths, the overflow-free wrap of the most-negative value divided by -1, and both forms of divide by zero. The 33-cycle latency is short enough that each operation is also checked for its exact done cycle, for a restart pulse sent in the middle of a run, and for unchanged result registers while busy.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mdu_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic commit;
  } mdu_strobe_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  output mdu_strobe_t ctl,
  output logic        busyOut,
  output logic        doneOut
);

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  mdu_state_e state;
  logic [CW-1:0] stepCnt;

  always_comb begin
    ctl.load   = startIn && (state == ST_IDLE);
    ctl.step   = (state == ST_RUN);
    ctl.commit = (state == ST_FIN);
  end

  assign busyOut = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= ctl.commit;
      unique case (state)
        ST_IDLE: if (startIn) begin
          state   <= ST_RUN;
          stepCnt <= '0;
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: an accepted start makes the unit busy on the next cycle
  p_start_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busyOut) |=> busyOut);

  // R2: done lasts a single cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R2: busy falls exactly when done appears
  p_busy_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyOut) |-> doneOut);

  // R2: done and busy never overlap
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !busyOut);

endmodule

// File: rtl/mdu_dpath.sv
module mdu_dpath
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdu_strobe_t      ctl,
  input  logic [1:0]       opIn,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic [WIDTH-1:0] hiReg,
  output logic [WIDTH-1:0] loReg
);

  localparam int W2 = 2 * WIDTH;

  // working state
  logic [WIDTH:0]   accHi;    // product upper part or partial remainder
  logic [WIDTH-1:0] accLo;    // multiplier bits or quotient bits
  logic [WIDTH-1:0] opB;      // multiplicand or divisor magnitude
  logic [WIDTH-1:0] origA;
  logic             isDiv, negRes, negRem, divZero;

  // operand conditioning
  logic             signedOp, divOp, aNeg, bNeg;
  logic [WIDTH-1:0] absA, absB;

  always_comb begin
    signedOp = (opIn == OP_MULS) || (opIn == OP_DIVS);
    divOp    = opIn[1];
    aNeg     = signedOp && srcA[WIDTH-1];
    bNeg     = signedOp && srcB[WIDTH-1];
    absA     = aNeg ? (~srcA + 1'b1) : srcA;
    absB     = bNeg ? (~srcB + 1'b1) : srcB;
  end

  // one iteration of either algorithm
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   mulSum, shifted, diff;
  logic             diffNeg;

  always_comb begin
    addend  = accLo[0] ? opB : '0;
    mulSum  = {1'b0, accHi[WIDTH-1:0]} + {1'b0, addend};
    shifted = {accHi[WIDTH-1:0], accLo[WIDTH-1]};
    diff    = shifted - {1'b0, opB};
    diffNeg = diff[WIDTH];
  end

  // sign correction at commit
  logic [W2-1:0]    prodRaw, prodFix;
  logic [WIDTH-1:0] quotFix, remFix, nextHi, nextLo;

  always_comb begin
    prodRaw = {accHi[WIDTH-1:0], accLo};
    prodFix = negRes ? (~prodRaw + 1'b1) : prodRaw;
    quotFix = negRes ? (~accLo + 1'b1) : accLo;
    remFix  = negRem ? (~accHi[WIDTH-1:0] + 1'b1) : accHi[WIDTH-1:0];
    if (!isDiv) begin
      nextHi = prodFix[W2-1:WIDTH];
      nextLo = prodFix[WIDTH-1:0];
    end else if (divZero) begin
      nextHi = origA;
      nextLo = '1;
    end else begin
      nextHi = remFix;
      nextLo = quotFix;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accHi   <= '0;
      accLo   <= '0;
      opB     <= '0;
      origA   <= '0;
      isDiv   <= 1'b0;
      negRes  <= 1'b0;
      negRem  <= 1'b0;
      divZero <= 1'b0;
    end else if (ctl.load) begin
      accHi   <= '0;
      accLo   <= divOp ? absA : absB;
      opB     <= divOp ? absB : absA;
      origA   <= srcA;
      isDiv   <= divOp;
      negRes  <= aNeg ^ bNeg;
      negRem  <= aNeg;
      divZero <= (srcB == '0);
    end else if (ctl.step) begin
      if (isDiv) begin
        accHi <= diffNeg ? shifted : diff;
        accLo <= {accLo[WIDTH-2:0], ~diffNeg};
      end else begin
        {accHi, accLo} <= {1'b0, mulSum, accLo[WIDTH-1:1]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg <= '0;
      loReg <= '0;
    end else if (ctl.commit) begin
      hiReg <= nextHi;
      loReg <= nextLo;
    end
  end

  // R9: result registers move only on a commit strobe
  p_hold_results_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> ($stable(hiReg) && $stable(loReg)));

  // R8: operands are captured only on an accepted start
  p_no_reload_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(opB) && $stable(isDiv) && $stable(origA)));

  // R7: divide by zero commits all ones and the dividend
  p_div_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commit && isDiv && divZero) |=> ((loReg == '1) && (hiReg == origA)));

endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [1:0]       opIn,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);

  mdu_strobe_t ctl;

  mdu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .ctl     (ctl),
    .busyOut (busy),
    .doneOut (done)
  );

  mdu_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .opIn  (opIn),
    .srcA  (srcA),
    .srcB  (srcB),
    .hiReg (hiOut),
    .loReg (loOut)
  );

  // R1: idle after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> (!busy && !done && hiOut == '0 && loOut == '0));

endmodule

// File: tb/sim_mdu_unit.sv
`timescale 1ns/1ps
module sim_mdu_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [1:0]  opIn = 2'b00;
  logic [31:0] srcA = '0, srcB = '0;
  logic        busy, done;
  logic [31:0] hiOut, loOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] hi;
    logic [31:0] lo;
    string       tag;
  } exp_t;

  exp_t scoreQ[$];
  logic [31:0] modelHi = '0, modelLo = '0;

  always #2.5 clk = ~clk;

  mdu_unit #(.WIDTH(32)) u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opIn(opIn),
    .srcA(srcA), .srcB(srcB), .busy(busy), .done(done),
    .hiOut(hiOut), .loOut(loOut)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // reference model of the requirements
  function automatic exp_t model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    longint sa, sb, sp, sq, sr;
    longint unsigned ua, ub, up;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'h0, a};
    ub = {32'h0, b};
    case (op)
      2'b00: begin sp = sa * sb; e.hi = sp[63:32]; e.lo = sp[31:0]; e.tag = "R3"; end
      2'b01: begin up = ua * ub; e.hi = up[63:32]; e.lo = up[31:0]; e.tag = "R4"; end
      2'b10: begin
        if (b == 0) begin e.hi = a; e.lo = '1; e.tag = "R7"; end
        else begin sq = sa / sb; sr = sa % sb; e.hi = sr[31:0]; e.lo = sq[31:0]; e.tag = "R5"; end
      end
      default: begin
        if (b == 0) begin e.hi = a; e.lo = '1; e.tag = "R7"; end
        else begin e.hi = a % b; e.lo = a / b; e.tag = "R6"; end
      end
    endcase
    return e;
  endfunction

  // driver: pushes expectation, starts op, checks timing and hold behaviour
  task automatic runOp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input bit interfere);
    exp_t e;
    int cyc;
    e = model(op, a, b);
    scoreQ.push_back(e);
    @(negedge clk);
    opIn = op; srcA = a; srcB = b; startIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startIn = 1'b0;
    check("R2 busy after start", {63'h0, busy}, 64'h1);
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (cyc == 5 && interfere) begin
        // R8: restart with other operands must be ignored
        opIn = ~op; srcA = ~a; srcB = b ^ 32'h5a5a_0001; startIn = 1'b1;
      end else begin
        startIn = 1'b0;
      end
      if (cyc == 10) check("R9 hold while busy", {hiOut, loOut}, {modelHi, modelLo});
    end
    check(interfere ? "R8 R2 done cycle" : "R2 done cycle", 64'(cyc), 64'd33);
    @(negedge clk);
    check("R2 done single pulse", {62'h0, done, busy}, 64'h0);
    modelHi = e.hi;
    modelLo = e.lo;
  endtask

  // monitor: compare results as they are committed
  always @(negedge clk) begin
    if (rstN && done) begin
      if (scoreQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        e = scoreQ.pop_front();
        check(e.tag, {hiOut, loOut}, {e.hi, e.lo});
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset busy/done", {62'h0, busy, done}, 64'h0);
    check("R1 reset hi/lo", {hiOut, loOut}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {62'h0, busy, done}, 64'h0);

    // R3 signed multiply
    runOp(2'b00, 32'd7, 32'd6, 0);
    runOp(2'b00, 32'hFFFF_FFFD, 32'd1000, 0);
    runOp(2'b00, 32'h8000_0000, 32'h8000_0000, 0);
    runOp(2'b00, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 0);
    // R4 unsigned multiply
    runOp(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    runOp(2'b01, 32'h1234_5678, 32'h9ABC_DEF0, 0);
    runOp(2'b01, 32'h0, 32'hDEAD_BEEF, 0);
    // R5 signed divide
    runOp(2'b10, 32'd100, 32'd7, 0);
    runOp(2'b10, 32'hFFFF_FF9C, 32'd7, 0);
    runOp(2'b10, 32'd100, 32'hFFFF_FFF9, 0);
    runOp(2'b10, 32'hFFFF_FF9C, 32'hFFFF_FFF9, 0);
    runOp(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    // R6 unsigned divide
    runOp(2'b11, 32'hFFFF_FFFF, 32'd10, 0);
    runOp(2'b11, 32'h8000_0000, 32'h8000_0001, 0);
    runOp(2'b11, 32'd5, 32'd9, 0);
    // R7 divide by zero
    runOp(2'b11, 32'hCAFE_0123, 32'h0, 0);
    runOp(2'b10, 32'hF000_0001, 32'h0, 0);
    // R8 restart while busy ignored
    runOp(2'b00, 32'hFFFF_FF00, 32'd3, 1);
    runOp(2'b11, 32'd1_000_000, 32'd37, 1);

    repeat (3) @(negedge clk);
    check("R2 all results seen", 64'(scoreQ.size()), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule